// File: doc/BRIEF.md
# SPI Command Frame Receiver for a Dual-Channel Resistor Controller

This block is the serial front end of a controller that drives two digitally programmed resistor channels. A host shifts 24-bit words into it over an SPI-style link, most significant bit first, with data sampled on the rising clock edge in either mode 0 or mode 3. Each word carries an operation code, a storage address and a data value. Nothing executes while bits arrive: when chip-select returns high, the block checks the number of bits received and runs the word only if that number is a whole multiple of 24.

Two channel registers (10-bit codes, reset to midscale) and a 16-word by 16-bit shadow store, modelled as plain registers, sit behind the decoder. The store's words 0 and 1 hold the power-up codes of the two channels. A write-protect input blocks every operation that would change a channel register or the store, while still allowing reloads from the store. An active-low preset input also reloads both channels. A chip-select pulse with no clock edges runs the last accepted word again. The serial output carries the bit leaving the 24-bit shift register so that a second device can be chained behind this one.

All serial inputs are assumed to be synchronous to the system clock `clk`, which must toggle at least four times per serial clock period.

Top module: `rdac_spi_frontend`

## Requirements
- R1: After reset both channel codes read 512, the store-write strobe is low and the serial output enable is low.
- R2: A word is laid out as operation [23:20], address [19:16], data [15:0]. It executes only in the clock cycle after chip-select rises with a nonzero bit count that is a multiple of 24. For 48 bits, only the last 24 received are executed.
- R3: A chip-select rise after a nonzero count that is not a multiple of 24 executes nothing. If the count is also not a multiple of 4, the shift register is cleared to zero. If it is a multiple of 4, its contents are kept.
- R4: Operation 4 (register write) loads channel address[0] with the data, with values above 1023 saturating to 1023.
- R5: Operation 3 (store write) writes the data to store word address and pulses the store-write strobe for one cycle with that address and data. Address 15 is never written and gives no strobe.
- R6: Operation 1 reloads channel address[0] from store word address[0]. Operation 5 reloads both channels from words 0 and 1. Operation 2 copies channel address[0] into store word address[0], with a strobe. Reloaded values saturate at 1023. Operation 0 and codes 6 to 15 do nothing.
- R7: While the write-protect input is low, operations 2, 3 and 4 change nothing and give no strobe. Operations 1 and 5 still execute.
- R8: While the preset input is low, both channels load from store words 0 and 1 (saturated) on every clock. Serial commands completing in those cycles are dropped.
- R9: A chip-select pulse with no serial clock edges re-executes the last word that passed the length check. Before any word has passed, it does nothing.
- R10: The serial output shows bit 23 of the shift register. Its enable is high exactly while chip-select is low. In a 48-bit frame, the first 24 bits received appear on the output during the last 24 clocks.
- R11: Bits are sampled on rising serial clock edges while chip-select is low, whether the clock idles low (mode 0) or high (mode 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| spi_sck | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Active-low chip-select |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out, chaining output |
| spi_miso_oe | output | 1 | Output enable for spi_miso (low means released) |
| wp_n | input | 1 | Active-low write protect |
| pr_n | input | 1 | Active-low preset (reload channels from store) |
| ch0_code | output | 10 | Channel 0 register |
| ch1_code | output | 10 | Channel 1 register |
| mem_we | output | 1 | One-cycle store-write strobe |
| mem_waddr | output | 4 | Store word address of the strobed write |
| mem_wdata | output | 16 | Data of the strobed write |

## Verification
A wrong bit counter shows up one cycle after chip-select rises, either as a channel code or store strobe that should not change or as a missed execution. A corrupted shift register shows up on the serial output within a bit time, because that output exposes bit 23 on every serial clock. A lost or stale replay word shows up on the bare chip-select pulse that follows. The store has no read port, so a bad store word only appears after a reload or preset, which is why reloads follow every kind of store write in the sequence.

// File: rtl/rdac_spi_pkg.sv
package rdac_spi_pkg;
  localparam int OP_FIELD_W   = 4;
  localparam int ADDR_FIELD_W = 4;

  typedef enum logic [OP_FIELD_W-1:0] {
    OP_NOP         = 4'd0,
    OP_RELOAD_ONE  = 4'd1,
    OP_SAVE_ONE    = 4'd2,
    OP_STORE_WRITE = 4'd3,
    OP_REG_WRITE   = 4'd4,
    OP_RELOAD_BOTH = 4'd5
  } op_e;
endpackage

// File: rtl/rdac_rst_sync.sv
module rdac_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic stage1;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      stage1     <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage1     <= 1'b1;
      rst_n_sync <= stage1;
    end
  end
endmodule

// File: rtl/rdac_frame_rx.sv
module rdac_frame_rx #(
  parameter int WORD_W = 24,
  parameter int NIB    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              frame_ok,
  output logic              bare_pulse,
  output logic [WORD_W-1:0] word,
  output logic              sdo
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] NIB_C    = CNT_W'(NIB);

  logic              sck_q, cs_q;
  logic [WORD_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              seen_q, seen_d;
  logic              sck_rise, cs_rise, cs_fall, odd_len;

  assign sck_rise = sck & ~sck_q & ~cs_n;
  assign cs_rise  = cs_n & ~cs_q;
  assign cs_fall  = ~cs_n & cs_q;
  assign odd_len  = (cnt_q % NIB_C) != '0;

  always_comb begin
    sr_d   = sr_q;
    cnt_d  = cnt_q;
    seen_d = seen_q;
    if (cs_fall) begin
      cnt_d  = '0;
      seen_d = 1'b0;
    end else if (sck_rise) begin
      sr_d   = {sr_q[WORD_W-2:0], mosi};
      cnt_d  = (cnt_q == LAST_BIT) ? '0 : cnt_q + 1'b1;
      seen_d = 1'b1;
    end else if (cs_rise) begin
      cnt_d  = '0;
      seen_d = 1'b0;
      if (seen_q && odd_len) sr_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      cs_q   <= 1'b1;
      sr_q   <= '0;
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      sck_q  <= sck;
      cs_q   <= cs_n;
      sr_q   <= sr_d;
      cnt_q  <= cnt_d;
      seen_q <= seen_d;
    end
  end

  assign frame_ok   = cs_rise & seen_q & (cnt_q == '0);
  assign bare_pulse = cs_rise & ~seen_q;
  assign word       = sr_q;
  assign sdo        = sr_q[WORD_W-1];

  // R3
  discard_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && seen_q && odd_len) |=> (sr_q == '0));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && cs_q) |=> $stable(sr_q));
endmodule

// File: rtl/rdac_cmd_replay.sv
module rdac_cmd_replay #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_ok,
  input  logic              bare_pulse,
  input  logic [WORD_W-1:0] word,
  output logic              issue,
  output logic [WORD_W-1:0] issue_word
);
  logic [WORD_W-1:0] last_q, last_d;
  logic              have_q, have_d;

  assign issue      = frame_ok | (bare_pulse & have_q);
  assign issue_word = frame_ok ? word : last_q;

  always_comb begin
    last_d = last_q;
    have_d = have_q;
    if (frame_ok) begin
      last_d = word;
      have_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      have_q <= 1'b0;
    end else begin
      last_q <= last_d;
      have_q <= have_d;
    end
  end

  // R9
  replay_needs_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bare_pulse && !have_q) |-> !issue);
endmodule

// File: rtl/rdac_wiper_store.sv
module rdac_wiper_store
  import rdac_spi_pkg::*;
#(
  parameter int REG_W     = 10,
  parameter int DATA_W    = 16,
  parameter int MEM_DEPTH = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    issue,
  input  logic [OP_FIELD_W-1:0]   op,
  input  logic [ADDR_FIELD_W-1:0] addr,
  input  logic [DATA_W-1:0]       data,
  input  logic                    wp_n,
  input  logic                    pr_n,
  output logic [REG_W-1:0]        ch0,
  output logic [REG_W-1:0]        ch1,
  output logic                    mem_we,
  output logic [$clog2(MEM_DEPTH)-1:0] mem_waddr,
  output logic [DATA_W-1:0]       mem_wdata
);
  localparam int ADDR_W = $clog2(MEM_DEPTH);
  localparam logic [REG_W-1:0]  MID      = REG_W'(1 << (REG_W - 1));
  localparam logic [DATA_W-1:0] MAX_CODE = DATA_W'((1 << REG_W) - 1);
  localparam logic [ADDR_W-1:0] RESERVED = ADDR_W'(MEM_DEPTH - 1);

  logic [REG_W-1:0]  ch_q [2];
  logic [REG_W-1:0]  ch_d [2];
  logic [DATA_W-1:0] mem_q [MEM_DEPTH];
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_val;
  logic              sel;
  logic [ADDR_W-1:0] sel_addr;
  logic [ADDR_W-1:0] tgt_addr;

  function automatic logic [REG_W-1:0] clamp_code(input logic [DATA_W-1:0] v);
    if (v > MAX_CODE) return MAX_CODE[REG_W-1:0];
    return v[REG_W-1:0];
  endfunction

  assign sel      = addr[0];
  assign sel_addr = {{(ADDR_W-1){1'b0}}, sel};
  assign tgt_addr = addr[ADDR_W-1:0];

  always_comb begin
    ch_d    = ch_q;
    wr_en   = 1'b0;
    wr_addr = '0;
    wr_val  = '0;
    if (!pr_n) begin
      ch_d[0] = clamp_code(mem_q[0]);
      ch_d[1] = clamp_code(mem_q[1]);
    end else if (issue) begin
      case (op)
        OP_RELOAD_ONE:  ch_d[sel] = clamp_code(mem_q[sel_addr]);
        OP_RELOAD_BOTH: begin
          ch_d[0] = clamp_code(mem_q[0]);
          ch_d[1] = clamp_code(mem_q[1]);
        end
        OP_REG_WRITE:   if (wp_n) ch_d[sel] = clamp_code(data);
        OP_SAVE_ONE:    if (wp_n) begin
          wr_en   = 1'b1;
          wr_addr = sel_addr;
          wr_val  = DATA_W'(ch_q[sel]);
        end
        OP_STORE_WRITE: if (wp_n && (tgt_addr != RESERVED)) begin
          wr_en   = 1'b1;
          wr_addr = tgt_addr;
          wr_val  = data;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q[0]   <= MID;
      ch_q[1]   <= MID;
      mem_we    <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= '0;
      for (int i = 0; i < MEM_DEPTH; i++)
        mem_q[i] <= (i < 2) ? DATA_W'(MID) : '0;
    end else begin
      ch_q[0] <= ch_d[0];
      ch_q[1] <= ch_d[1];
      mem_we  <= wr_en;
      if (wr_en) begin
        mem_waddr      <= wr_addr;
        mem_wdata      <= wr_val;
        mem_q[wr_addr] <= wr_val;
      end
    end
  end

  assign ch0 = ch_q[0];
  assign ch1 = ch_q[1];

  // R7
  wp_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_n |=> !mem_we);

  // R5
  reserved_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_waddr != RESERVED));

  // R8
  preset_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pr_n |=> (ch_q[0] == clamp_code($past(mem_q[0]))) && (ch_q[1] == clamp_code($past(mem_q[1]))));
endmodule

// File: rtl/rdac_spi_frontend.sv
module rdac_spi_frontend
  import rdac_spi_pkg::*;
#(
  parameter int WORD_W    = 24,
  parameter int REG_W     = 10,
  parameter int DATA_W    = 16,
  parameter int MEM_DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         spi_sck,
  input  logic                         spi_cs_n,
  input  logic                         spi_mosi,
  output logic                         spi_miso,
  output logic                         spi_miso_oe,
  input  logic                         wp_n,
  input  logic                         pr_n,
  output logic [REG_W-1:0]             ch0_code,
  output logic [REG_W-1:0]             ch1_code,
  output logic                         mem_we,
  output logic [$clog2(MEM_DEPTH)-1:0] mem_waddr,
  output logic [DATA_W-1:0]            mem_wdata
);
  localparam int OP_LSB   = WORD_W - OP_FIELD_W;
  localparam int ADDR_LSB = OP_LSB - ADDR_FIELD_W;

  logic              rst_n_i;
  logic              frame_ok, bare_pulse, issue;
  logic [WORD_W-1:0] word, issue_word;

  rdac_rst_sync u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_i)
  );

  rdac_frame_rx #(.WORD_W(WORD_W), .NIB(4)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .sck        (spi_sck),
    .cs_n       (spi_cs_n),
    .mosi       (spi_mosi),
    .frame_ok   (frame_ok),
    .bare_pulse (bare_pulse),
    .word       (word),
    .sdo        (spi_miso)
  );

  rdac_cmd_replay #(.WORD_W(WORD_W)) u_replay (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .frame_ok   (frame_ok),
    .bare_pulse (bare_pulse),
    .word       (word),
    .issue      (issue),
    .issue_word (issue_word)
  );

  rdac_wiper_store #(.REG_W(REG_W), .DATA_W(DATA_W), .MEM_DEPTH(MEM_DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .issue     (issue),
    .op        (issue_word[WORD_W-1:OP_LSB]),
    .addr      (issue_word[OP_LSB-1:ADDR_LSB]),
    .data      (issue_word[DATA_W-1:0]),
    .wp_n      (wp_n),
    .pr_n      (pr_n),
    .ch0       (ch0_code),
    .ch1       (ch1_code),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata)
  );

  assign spi_miso_oe = ~spi_cs_n;

  // R2
  exec_at_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    issue |-> spi_cs_n);
endmodule

// File: tb/sim_rdac_spi_frontend.sv
module sim_rdac_spi_frontend;
  logic clk = 0;
  logic rst_n = 0;
  logic sck = 0, cs_n = 1, mosi = 0, wp_n = 1, pr_n = 1;
  logic miso, miso_oe, mem_we;
  logic [9:0] ch0, ch1;
  logic [3:0] mem_waddr;
  logic [15:0] mem_wdata;

  int compared = 0, mismatched = 0;
  int we_count = 0, last_wa = -1, last_wd = -1;

  always #5 clk = ~clk;

  rdac_spi_frontend u0 (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .wp_n(wp_n), .pr_n(pr_n),
    .ch0_code(ch0), .ch1_code(ch1), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata)
  );

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_ch[2];
  int m_mem[16];
  bit m_q[$];
  int m_cnt;
  bit m_have;
  logic [23:0] m_last;
  bit m_we;
  int m_wa, m_wd;
  bit p_sck, p_cs;
  int boot;

  function automatic int sat(input int v);
    return (v > 1023) ? 1023 : v;
  endfunction

  task automatic m_reset();
    m_ch[0] = 512; m_ch[1] = 512;
    foreach (m_mem[i]) m_mem[i] = (i < 2) ? 512 : 0;
    m_q.delete();
    repeat (24) m_q.push_back(1'b0);
    m_cnt = 0; m_have = 0; m_last = 0; m_we = 0; m_wa = 0; m_wd = 0;
    p_sck = 0; p_cs = 1;
  endtask

  task automatic m_run(input logic [23:0] w);
    int op, ad, dt, s;
    op = w[23:20]; ad = w[19:16]; dt = w[15:0]; s = ad % 2;
    case (op)
      1: m_ch[s] = sat(m_mem[s]);
      5: begin m_ch[0] = sat(m_mem[0]); m_ch[1] = sat(m_mem[1]); end
      4: if (wp_n) m_ch[s] = sat(dt);
      2: if (wp_n) begin m_we = 1; m_wa = s; m_wd = m_ch[s]; m_mem[s] = m_ch[s]; end
      3: if (wp_n && ad != 15) begin m_we = 1; m_wa = ad; m_wd = dt; m_mem[ad] = dt; end
      default: ;
    endcase
  endtask

  task automatic m_step();
    bit go;
    logic [23:0] w;
    go = 0; w = 0; m_we = 0;
    if (!cs_n && p_cs) m_cnt = 0;
    else if (sck && !p_sck && !cs_n) begin
      m_q.push_back(mosi); void'(m_q.pop_front()); m_cnt++;
    end else if (cs_n && !p_cs) begin
      if (m_cnt == 0) begin
        if (m_have) begin go = 1; w = m_last; end
      end else if (m_cnt % 24 == 0) begin
        for (int i = 0; i < 24; i++) w[23-i] = m_q[i];
        m_last = w; m_have = 1; go = 1;
      end else if (m_cnt % 4 != 0) begin
        foreach (m_q[i]) m_q[i] = 1'b0;
      end
      m_cnt = 0;
    end
    if (!pr_n) begin m_ch[0] = sat(m_mem[0]); m_ch[1] = sat(m_mem[1]); end
    else if (go) m_run(w);
    p_sck = sck; p_cs = cs_n;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin m_reset(); boot = 0; end
    else if (boot < 2) boot++;
    else begin
      m_step();
      #3;
      chk("R4/R6 ch0 vs model", ch0, m_ch[0]);
      chk("R4/R6 ch1 vs model", ch1, m_ch[1]);
      chk("R5 strobe vs model", mem_we, m_we);
      if (m_we) begin
        chk("R5 strobe addr vs model", mem_waddr, m_wa);
        chk("R5 strobe data vs model", mem_wdata, m_wd);
      end
      chk("R10/R3 miso vs model", miso, m_q[0]);
      chk("R10 miso_oe vs model", miso_oe, !cs_n);
      if (mem_we) begin we_count++; last_wa = mem_waddr; last_wd = mem_wdata; end
    end
  end

  function automatic logic [23:0] mk(input int op, input int ad, input int dt);
    return {op[3:0], ad[3:0], dt[15:0]};
  endfunction

  task automatic send(input logic [47:0] bits, input int n, input bit mode3);
    @(negedge clk); sck = mode3;
    @(negedge clk); cs_n = 0;
    repeat (2) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      sck = 0; mosi = bits[i];
      repeat (2) @(negedge clk);
      sck = 1;
      repeat (2) @(negedge clk);
    end
    if (!mode3) sck = 0;
    repeat (2) @(negedge clk);
    cs_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic bare();
    @(negedge clk); cs_n = 0;
    repeat (2) @(negedge clk);
    cs_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 ch0 reset", ch0, 512);
    chk("R1 ch1 reset", ch1, 512);
    chk("R1 miso_oe reset", miso_oe, 0);
    chk("R1 strobe reset", mem_we, 0);

    // R9 first bare pulse after reset does nothing
    bare();
    chk("R9 no replay before first word", ch0, 512);
    chk("R9 no strobe before first word", we_count, 0);

    // R2 R4 mode 0 register write
    send({24'h0, mk(4, 0, 300)}, 24, 0);
    chk("R2/R4 ch0 write", ch0, 300);
    // R4 R11 mode 3 with saturation
    send({24'h0, mk(4, 1, 2000)}, 24, 1);
    chk("R4/R11 ch1 saturated", ch1, 1023);

    // R3 wrong lengths
    send({24'h0, mk(4, 0, 5)}, 23, 0);
    chk("R3 23-bit ignored", ch0, 300);
    send({23'h0, mk(4, 0, 5), 1'b1}, 25, 1);
    chk("R3 25-bit ignored", ch0, 300);
    send({36'h0, 12'h4A5}, 12, 0);
    chk("R3 12-bit ignored", ch0, 300);

    // R2 R10 48-bit frame, last word executes
    send({mk(4, 0, 7), mk(4, 0, 9)}, 48, 0);
    chk("R2 48-bit last word", ch0, 9);

    // R5 store writes
    send({24'h0, mk(3, 15, 16'hBEEF)}, 24, 0);
    chk("R5 reserved word no strobe", we_count, 0);
    send({24'h0, mk(3, 3, 16'h1234)}, 24, 1);
    chk("R5 strobe count", we_count, 1);
    chk("R5 strobe addr", last_wa, 3);
    chk("R5 strobe data", last_wd, 16'h1234);

    // R9 replay
    bare();
    chk("R9 replay strobe count", we_count, 2);
    chk("R9 replay addr", last_wa, 3);

    // R6 reload and save
    send({24'h0, mk(3, 0, 100)}, 24, 0);
    send({24'h0, mk(1, 0, 0)}, 24, 0);
    chk("R6 reload one", ch0, 100);
    send({24'h0, mk(2, 1, 0)}, 24, 1);
    chk("R6 save strobe data", last_wd, 1023);
    chk("R6 save strobe addr", last_wa, 1);
    send({24'h0, mk(4, 1, 5)}, 24, 0);
    send({24'h0, mk(4, 0, 33)}, 24, 0);
    send({24'h0, mk(5, 0, 0)}, 24, 0);
    chk("R6 reload both ch0", ch0, 100);
    chk("R6 reload both ch1", ch1, 1023);
    send({24'h0, mk(9, 0, 77)}, 24, 0);
    chk("R6 unused code no effect", ch0, 100);

    // R7 write protect
    send({24'h0, mk(4, 1, 7)}, 24, 0);
    wp_n = 0;
    send({24'h0, mk(4, 1, 50)}, 24, 0);
    chk("R7 reg write blocked", ch1, 7);
    send({24'h0, mk(3, 0, 700)}, 24, 1);
    chk("R7 store write blocked", we_count, 4);
    send({24'h0, mk(2, 0, 0)}, 24, 0);
    chk("R7 save blocked", we_count, 4);
    send({24'h0, mk(1, 1, 0)}, 24, 0);
    chk("R7 reload allowed", ch1, 1023);
    wp_n = 1;

    // R8 preset
    send({24'h0, mk(3, 1, 16'hFFFF)}, 24, 0);
    send({24'h0, mk(4, 0, 1)}, 24, 0);
    send({24'h0, mk(4, 1, 2)}, 24, 0);
    @(negedge clk); pr_n = 0;
    repeat (3) @(negedge clk); pr_n = 1;
    @(negedge clk);
    chk("R8 preset ch0", ch0, 100);
    chk("R8 preset ch1", ch1, 1023);

    // R10 output enable while selected; R9 replay of last word
    @(negedge clk); cs_n = 0;
    @(negedge clk);
    chk("R10 miso_oe while selected", miso_oe, 1);
    cs_n = 1;
    @(negedge clk);
    chk("R10 miso_oe released", miso_oe, 0);
    repeat (3) @(negedge clk);
    chk("R9 replay after preset", ch1, 2);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule